// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block produces the active-low processor reset for a system. The reset line is open-drain: the block only enables a pull-down (`pull_o`) and reads the line back through `pin_i`. Three causes pull the line low. The first is a supply that is out of tolerance. The second is a pushbutton wired onto the same reset line. The third is a watchdog that the processor must restart with falling edges on a strobe. Every delay is counted in ticks of a shared timebase (`tick_i`, nominally one per millisecond), so a reset pulse lasts `PULSE_TICKS` ticks. The watchdog period is one, two or four times `WD_UNIT_TICKS`.

The pushbutton is sensed on the pin the block itself drives. A press starts one reset pulse. If the line is still held low once that pulse has ended and the synchronizers have settled, the block releases its drive and waits for the button to be released. On release it issues a second pulse. Line edges that come from the block's own drive never start a pulse. The strobe, the power flag and the sensed line each pass through a two-flop synchronizer. The timeout-select register holds its power-up value until software writes it.

Top module: `rst_supervisor`

## Requirements
- R1: While `pwr_ok_i` is low, `pull_o` goes high within the synchronizer latency and stays high. After `pwr_ok_i` returns high, `pull_o` stays high for a further `PULSE_TICKS` ticks plus the synchronizer latency.
- R2: When no reset cycle is in progress, a falling edge on the sensed reset line raises `pull_o` for exactly `PULSE_TICKS` ticks.
- R3: If the line is still low after the press pulse and a settle time of `SYNC_STAGES`+2 cycles, `pull_o` stays low until the line rises. That rising edge starts a second pulse of `PULSE_TICKS` ticks.
- R4: If the line is released before the press pulse ends, exactly one pulse is produced.
- R5: Line edges caused by the block's own pull-down never start a pulse. After a power or watchdog pulse, `pull_o` stays low until a new cause occurs.
- R6: Timeout select encoding: 2'b00 disables the watchdog, 2'b01 gives `WD_UNIT_TICKS`, 2'b10 gives 2×`WD_UNIT_TICKS`, and 2'b11 gives 4×`WD_UNIT_TICKS` ticks.
- R7: Reset (`rst_ni` low) holds `pull_o` high and sets the timeout select to 2'b11.
- R8: The watchdog counts only while reset is inactive, meaning `pull_o` is low and the sensed line is high. A falling edge on `strobe_ni` restarts the full period.
- R9: When the watchdog period expires, `pull_o` goes high for `PULSE_TICKS` ticks.
- R10: `rst_act_o` is high when `pull_o` is high or when the synchronized reset line is low.
- R11: A write through `wd_we_i` loads `wd_sel_i` into the select register and restarts the period using the newly written value.
- R12: Pulse and watchdog periods count `tick_i` pulses, not clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Supply in tolerance (from comparator) |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| pin_i | input | 1 | Sensed level of the reset line |
| strobe_ni | input | 1 | Watchdog strobe, falling edge restarts |
| wd_we_i | input | 1 | Write enable for the timeout select |
| wd_sel_i | input | 2 | Timeout select write data |
| pull_o | output | 1 | Reset line pull-down enable |
| rst_act_o | output | 1 | Reset currently active |

## Verification
The bench builds the block with `PULSE_TICKS`=8 and `WD_UNIT_TICKS`=10. This makes every pulse, settle window and all three watchdog periods span tens of cycles rather than hundreds of thousands, so exact pulse lengths and low gaps can be measured cycle by cycle. It models the line as `pin_i = ~(pull_o | button)`, so the block sees its own drive coming back. The button cases therefore cover held, short and released presses against real feedback. The tick is held high for most tests, which makes ticks equal to cycles. One test toggles the tick every cycle to show that periods scale with ticks.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [2:0] {
    ST_PWR,
    ST_PULSE,
    ST_SETTLE,
    ST_RUN,
    ST_WAIT_REL
  } rsv_state_e;

  typedef enum logic {
    SRC_OTHER,
    SRC_PRESS
  } rsv_src_e;

  localparam logic [1:0] WD_OFF     = 2'b00;
  localparam logic [1:0] WD_X1      = 2'b01;
  localparam logic [1:0] WD_X2      = 2'b10;
  localparam logic [1:0] WD_X4      = 2'b11;
  localparam logic [1:0] WD_SEL_RST = WD_X4;
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int unsigned W               = 1,
  parameter int unsigned STAGES          = 2,
  parameter logic [W-1:0] RST_VAL        = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rsv_timer.sv
module rsv_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= load_val_i;
    else if (dec_i && (cnt_q != '0))    cnt_q <= cnt_q - W'(1);
  end

  // last decrement of the period
  assign expire_o = dec_i && (cnt_q == W'(1));
endmodule

// File: rtl/rsv_wdog.sv
module rsv_wdog import rsv_pkg::*; #(
  parameter int unsigned UNIT_TICKS = 250,
  parameter int unsigned CNT_W      = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       hold_i,
  input  logic       kick_i,
  input  logic       sel_we_i,
  input  logic [1:0] sel_i,
  output logic       expire_o
);
  logic [1:0]       sel_q, sel_nxt;
  logic [CNT_W-1:0] period;
  logic             load, dec, tmr_exp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= WD_SEL_RST;
    else if (sel_we_i) sel_q <= sel_i;
  end

  assign sel_nxt = sel_we_i ? sel_i : sel_q;

  always_comb begin
    unique case (sel_nxt)
      WD_X1:   period = CNT_W'(UNIT_TICKS);
      WD_X2:   period = CNT_W'(2 * UNIT_TICKS);
      WD_X4:   period = CNT_W'(4 * UNIT_TICKS);
      default: period = '0;
    endcase
  end

  assign load = hold_i | kick_i | sel_we_i;
  assign dec  = tick_i & ~hold_i & (sel_q != WD_OFF);

  rsv_timer #(.W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (period),
    .dec_i      (dec),
    .expire_o   (tmr_exp)
  );

  // a restart in the same cycle wins over expiry
  assign expire_o = tmr_exp & ~kick_i & ~sel_we_i;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor import rsv_pkg::*; #(
  parameter int unsigned PULSE_TICKS   = 250,
  parameter int unsigned WD_UNIT_TICKS = 250,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_ok_i,
  input  logic       tick_i,
  input  logic       pin_i,
  input  logic       strobe_ni,
  input  logic       wd_we_i,
  input  logic [1:0] wd_sel_i,
  output logic       pull_o,
  output logic       rst_act_o
);
  localparam int unsigned SETTLE_CYC = SYNC_STAGES + 2;
  localparam int unsigned PT_MAX     = (PULSE_TICKS > SETTLE_CYC) ? PULSE_TICKS : SETTLE_CYC;
  localparam int unsigned PT_W       = $clog2(PT_MAX + 1);
  localparam int unsigned WD_W       = $clog2(4 * WD_UNIT_TICKS + 1);

  rsv_state_e state_q, state_d;
  rsv_src_e   src_q, src_d;

  logic [2:0]      raw, syn;
  logic            pok_s, pin_s, stb_s;
  logic            pin_q, stb_q;
  logic            pin_fall, pin_rise, stb_fall;
  logic            press_det, release_det;
  logic            pt_load, pt_dec, pt_exp;
  logic [PT_W-1:0] pt_val;
  logic            wd_exp;

  assign raw = {pwr_ok_i, pin_i, strobe_ni};

  rsv_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (syn)
  );

  assign pok_s = syn[2];
  assign pin_s = syn[1];
  assign stb_s = syn[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b1;
      stb_q <= 1'b1;
    end else begin
      pin_q <= pin_s;
      stb_q <= stb_s;
    end
  end

  assign pin_fall    = pin_q & ~pin_s;
  assign pin_rise    = ~pin_q & pin_s;
  assign stb_fall    = stb_q & ~stb_s;
  assign press_det   = (state_q == ST_RUN) & pin_fall;
  assign release_det = (state_q == ST_WAIT_REL) & pin_rise;

  assign pull_o    = (state_q == ST_PWR) || (state_q == ST_PULSE);
  assign rst_act_o = pull_o | ~pin_s;

  rsv_timer #(.W(PT_W)) u_pulse_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (pt_load),
    .load_val_i (pt_val),
    .dec_i      (pt_dec),
    .expire_o   (pt_exp)
  );

  rsv_wdog #(.UNIT_TICKS(WD_UNIT_TICKS), .CNT_W(WD_W)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .hold_i   (rst_act_o),
    .kick_i   (stb_fall),
    .sel_we_i (wd_we_i),
    .sel_i    (wd_sel_i),
    .expire_o (wd_exp)
  );

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    pt_load = 1'b0;
    pt_val  = PT_W'(PULSE_TICKS);
    pt_dec  = 1'b0;
    unique case (state_q)
      ST_PWR: begin
        if (pok_s) begin
          state_d = ST_PULSE;
          src_d   = SRC_OTHER;
          pt_load = 1'b1;
        end
      end
      ST_PULSE: begin
        pt_dec = tick_i;
        if (pt_exp) begin
          state_d = ST_SETTLE;
          pt_load = 1'b1;
          pt_val  = PT_W'(SETTLE_CYC);
        end
      end
      ST_SETTLE: begin
        // own drive is still echoing through the synchronizer
        pt_dec = 1'b1;
        if (wd_exp) begin
          state_d = ST_PULSE;
          src_d   = SRC_OTHER;
          pt_load = 1'b1;
        end else if (pt_exp) begin
          state_d = (src_q == SRC_PRESS && !pin_s) ? ST_WAIT_REL : ST_RUN;
        end
      end
      ST_RUN: begin
        if (press_det) begin
          state_d = ST_PULSE;
          src_d   = SRC_PRESS;
          pt_load = 1'b1;
        end else if (wd_exp) begin
          state_d = ST_PULSE;
          src_d   = SRC_OTHER;
          pt_load = 1'b1;
        end
      end
      ST_WAIT_REL: begin
        if (release_det || wd_exp) begin
          state_d = ST_PULSE;
          src_d   = SRC_OTHER;
          pt_load = 1'b1;
        end
      end
      default: state_d = ST_PWR;
    endcase
    if (!pok_s) state_d = ST_PWR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWR;
      src_q   <= SRC_OTHER;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
    end
  end
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic pull_i,
  input logic pok_i,
  input logic press_i,
  input logic release_i,
  input logic wd_exp_i
);
  p_pwr_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pok_i |=> pull_i);

  p_press_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_i && pok_i |=> pull_i);

  p_release_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i && pok_i |=> pull_i);

  p_wd_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_i |-> !wd_exp_i);

  p_wd_fire_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_exp_i && pok_i |=> pull_i);
endmodule

bind rst_supervisor rsv_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pull_i    (pull_o),
  .pok_i     (pok_s),
  .press_i   (press_det),
  .release_i (release_det),
  .wd_exp_i  (wd_exp)
);

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
  localparam int P    = 8;
  localparam int UNIT = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwr_ok = 1'b1;
  logic       tick = 1'b1;
  logic       btn = 1'b0;
  logic       strobe_n = 1'b1;
  logic       wd_we = 1'b0;
  logic [1:0] wd_sel = 2'b00;
  logic       pin;
  logic       pull, rst_act;
  bit         tick_half = 1'b0;

  int checks = 0;
  int errors = 0;
  int w, len, hi, n, t, sel_r, iv;

  always #10 clk = ~clk;

  assign pin = ~(pull | btn);

  rst_supervisor #(.PULSE_TICKS(P), .WD_UNIT_TICKS(UNIT), .SYNC_STAGES(2)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .pwr_ok_i  (pwr_ok),
    .tick_i    (tick),
    .pin_i     (pin),
    .strobe_ni (strobe_n),
    .wd_we_i   (wd_we),
    .wd_sel_i  (wd_sel),
    .pull_o    (pull),
    .rst_act_o (rst_act)
  );

  function automatic int period(input int s);
    case (s)
      1: return UNIT;
      2: return 2 * UNIT;
      3: return 4 * UNIT;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse_len(input int lim, output int wn, output int ln);
    wn = 0;
    while (!pull && wn < lim) begin @(negedge clk); wn++; end
    ln = 0;
    while (pull && ln < 1000) begin @(negedge clk); ln++; end
  endtask

  task automatic count_high(input int k, output int h);
    h = 0;
    repeat (k) begin @(negedge clk); if (pull) h++; end
  endtask

  task automatic write_sel(input logic [1:0] v);
    wd_sel = v; wd_we = 1'b1;
    @(negedge clk);
    wd_we = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      tick = tick_half ? ~tick : 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    n = $urandom(32'd1234);
    cyc(3);
    // R7: reset state
    chk(pull === 1'b1, "R7 pull in reset", pull, 1);
    chk(rst_act === 1'b1, "R10 act in reset", rst_act, 1);
    rst_ni = 1'b1;
    pulse_len(5, w, len);
    chk(len >= P + 2 && len <= P + 4, "R7 power-up pulse", len, P + 3);
    // R7: default select 11 gives 4 units
    pulse_len(200, w, len);
    chk(w >= 4 * UNIT + 1 && w <= 4 * UNIT + 3, "R7 default period", w, 4 * UNIT + 2);
    chk(len == P, "R9 watchdog pulse len", len, P);
    write_sel(2'b00);
    cyc(10);
    chk(rst_act === 1'b0, "R10 idle act", rst_act, 0);

    // R6: disabled watchdog never fires
    count_high(100, hi);
    chk(hi == 0, "R6 sel 00 disabled", hi, 0);

    // R1: power fail
    pwr_ok = 1'b0;
    cyc(5);
    chk(pull === 1'b1, "R1 pull on power low", pull, 1);
    count_high(20, hi);
    chk(hi == 20, "R1 held while low", hi, 20);
    pwr_ok = 1'b1;
    len = 0;
    while (pull && len < 100) begin @(negedge clk); len++; end
    chk(len >= P + 1 && len <= P + 3, "R1 tail after power return", len, P + 2);
    // R5: no follow-up pulse from own drive
    count_high(30, hi);
    chk(hi == 0, "R5 no pulse after power pulse", hi, 0);

    // R2/R3/R10: held press then release
    btn = 1'b1;
    pulse_len(10, w, len);
    chk(len == P, "R2 press pulse len", len, P);
    cyc(8);
    chk(pull === 1'b0, "R3 no drive while held", pull, 0);
    chk(rst_act === 1'b1, "R10 act while held", rst_act, 1);
    btn = 1'b0;
    pulse_len(10, w, len);
    chk(len == P, "R3 release pulse len", len, P);
    cyc(10);
    chk(rst_act === 1'b0, "R10 act after release", rst_act, 0);

    // R4: short press
    btn = 1'b1;
    cyc(3);
    btn = 1'b0;
    pulse_len(10, w, len);
    chk(len == P, "R4 short press pulse", len, P);
    count_high(30, hi);
    chk(hi == 0, "R4 single pulse only", hi, 0);

    // R6/R9/R5: each period and gap after watchdog pulse
    for (int s = 1; s < 4; s++) begin
      t = period(s);
      write_sel(2'(s));
      n = 1;
      while (!pull && n < 200) begin @(negedge clk); n++; end
      chk(n >= t && n <= t + 2, "R6 period from write", n, t + 1);
      pulse_len(1, w, len);
      chk(len == P, "R9 expiry pulse", len, P);
      pulse_len(200, w, len);
      chk(w >= t + 1 && w <= t + 3, "R5 gap after own pulse", w, t + 2);
      write_sel(2'b00);
      cyc(10);
    end

    // R11: write restarts with new value
    write_sel(2'b01);
    cyc(6);
    write_sel(2'b10);
    n = 1;
    while (!pull && n < 200) begin @(negedge clk); n++; end
    chk(n >= 20 && n <= 22, "R11 restart on write", n, 21);
    pulse_len(1, w, len);
    write_sel(2'b00);
    cyc(10);

    // R8: watchdog held while button holds the line
    write_sel(2'b01);
    btn = 1'b1;
    pulse_len(10, w, len);
    count_high(40, hi);
    chk(hi == 0, "R8 no expiry while line low", hi, 0);
    write_sel(2'b00);
    btn = 1'b0;
    pulse_len(10, w, len);
    chk(len == P, "R3 release after long hold", len, P);
    cyc(10);

    // R8/R9: random strobing keeps reset away, stopping lets it fire
    for (int r = 0; r < 4; r++) begin
      sel_r = 1 + int'($urandom % 3);
      t = period(sel_r);
      write_sel(2'(sel_r));
      hi = 0;
      for (int k = 0; k < 12; k++) begin
        iv = 2 + int'($urandom % (t - 5));
        strobe_n = 1'b0;
        @(negedge clk); if (pull) hi++;
        strobe_n = 1'b1;
        repeat (iv - 1) begin @(negedge clk); if (pull) hi++; end
      end
      chk(hi == 0, "R8 strobes prevent reset", hi, 0);
      strobe_n = 1'b0;
      @(negedge clk);
      strobe_n = 1'b1;
      n = 1;
      while (!pull && n < 200) begin @(negedge clk); n++; end
      chk(n >= t + 2 && n <= t + 4, "R9 fire after last strobe", n, t + 3);
      pulse_len(1, w, len);
      write_sel(2'b00);
      cyc(10);
    end

    // R12: periods count ticks
    tick_half = 1'b1;
    cyc(2);
    btn = 1'b1;
    cyc(3);
    btn = 1'b0;
    pulse_len(10, w, len);
    chk(len >= 2 * P - 1 && len <= 2 * P + 1, "R12 half-rate tick pulse", len, 2 * P);
    tick_half = 1'b0;
    cyc(10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule